// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Victim Buffer

This block is a read-only cache. Its main store is a direct-mapped array of lines, and a small fully associative victim buffer sits beside it. Each lookup probes both structures in the same cycle. A hit in the main array returns the stored line on the next cycle.

When only the victim buffer holds the requested block, the buffered line moves back into its direct-mapped set. The line that was in that set takes the freed buffer slot. The requested data comes back on the next cycle, and no traffic goes to the next level. When neither structure holds the block, the cache sends a single request to the next-level memory and waits for the fill. The fill is written into the direct-mapped set. Any valid line it displaces is pushed into the victim buffer.

The cache handles one access at a time, and a miss blocks new requests until the fill has landed. Three counters report how many accesses were main hits, victim hits and misses. They exist so that a test environment can check the classification of each access.

Top module: `cache_vb_top`

## Requirements
- R1: After reset, `reqReady` is 1, `rspValid` and `memReqValid` are 0, and all three counters read 0.
- R2: A block held in the main array is answered with `rspValid`=1 and its line on `rspData` in the cycle after acceptance. No next-level request is made, and `hitCount` increments.
- R3: The set index of a block address is its low log2(SETS) bits, and the tag is the remaining upper bits. Two addresses with equal low bits but different upper bits compete for one set.
- R4: A fill that replaces a valid line pushes that line into the victim buffer. A fill into an empty set pushes nothing, so no buffered line is displaced.
- R5: A block found only in the victim buffer is answered in the cycle after acceptance, with no next-level request, and `victimHitCount` increments. The block returns to its set, and the former occupant of the set takes the buffer slot.
- R6: Pushes into the victim buffer overwrite slots in first-in first-out order. After VB_ENTRIES further pushes, the oldest pushed line is gone and an access to it misses.
- R7: When both structures miss, `memReqValid` rises in the cycle after acceptance, with the block address on `memReqAddr`. Both stay stable until `memReqReady`. In the cycle after `memRspValid`, the cache answers with `memRspData` and `missCount` increments.
- R8: Only one miss is outstanding. `reqReady` is 0 from the cycle after a miss is accepted until the cycle after the fill.
- R9: Each accepted request produces exactly one single-cycle `rspValid` pulse. `rspValid` is 0 in idle cycles.
- R10: At most one counter changes per cycle, by exactly one. The counters' sum equals the number of answered requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request present |
| reqReady | output | 1 | Cache can accept a request this cycle |
| reqAddr | input | ADDR_W | Block address of the request |
| rspValid | output | 1 | Response line valid (one cycle) |
| rspData | output | DATA_W | Response line |
| memReqValid | output | 1 | Next-level read request |
| memReqReady | input | 1 | Next level accepts the request |
| memReqAddr | output | ADDR_W | Block address sent to the next level |
| memRspValid | input | 1 | Fill data present |
| memRspData | input | DATA_W | Fill line |
| hitCount | output | CNT_W | Main-array hits |
| victimHitCount | output | CNT_W | Victim-buffer hits |
| missCount | output | CNT_W | Accesses sent to the next level |

## Verification
The hardest situation to reach from the ports is FIFO overwrite of a buffered line that is still wanted. That line has to be pushed first, and then exactly VB_ENTRIES later evictions must land in the buffer without any of them being swapped back. Directed stimulus reaches it with a chain of conflicting addresses on one set, ending in a re-access of the first one. A long random phase then draws addresses from a pool of six times the number of sets. This keeps swaps, empty-set fills and buffer overwrites interleaved, under varying next-level stall and latency. A behavioural queue model predicts every classification.

// File: rtl/cache_vb_pkg.sv
package cache_vb_pkg;

  // Strobes from control to datapath, valid in the cycle they are high.
  typedef struct packed {
    logic accept;   // request accepted this cycle
    logic hitMain;  // answer from main array
    logic swap;     // exchange victim entry with set occupant
    logic miss;     // both structures missed
    logic fill;     // next-level data arrives
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_MWAIT = 2'd2
  } ctrlState_t;

endpackage

// File: rtl/cache_vb_ctrl.sv
module cache_vb_ctrl
  import cache_vb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         mainHit,
  input  logic         vbHit,
  input  logic         memReqReady,
  input  logic         memRspValid,
  output logic         reqReady,
  output logic         memReqValid,
  output ctrlStrobes_t strobes
);

  ctrlState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    strobes     = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobes.accept = 1'b1;
          if (mainHit)    strobes.hitMain = 1'b1;
          else if (vbHit) strobes.swap    = 1'b1;
          else begin
            strobes.miss = 1'b1;
            stateNext    = ST_MREQ;
          end
        end
      end
      ST_MREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNext = ST_MWAIT;
      end
      ST_MWAIT: begin
        if (memRspValid) begin
          strobes.fill = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/cache_vb_datapath.sv
module cache_vb_datapath
  import cache_vb_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int SETS       = 4,
  parameter int VB_ENTRIES = 4,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] memRspData,
  output logic              mainHit,
  output logic              vbHit,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  victimHitCount,
  output logic [CNT_W-1:0]  missCount
);

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int VB_W  = $clog2(VB_ENTRIES);
  localparam logic [VB_W-1:0] VB_LAST = VB_W'(VB_ENTRIES - 1);

  // Main direct-mapped store
  logic [SETS-1:0]   mainValid;
  logic [TAG_W-1:0]  mainTag  [SETS];
  logic [DATA_W-1:0] mainData [SETS];

  // Fully associative victim buffer
  logic [VB_ENTRIES-1:0] vbValid;
  logic [ADDR_W-1:0]     vbAddr [VB_ENTRIES];
  logic [DATA_W-1:0]     vbData [VB_ENTRIES];
  logic [VB_W-1:0]       vbPtr;
  logic [VB_ENTRIES-1:0] vbMatch;
  logic [VB_W-1:0]       vbSel;

  logic [ADDR_W-1:0] pendAddr;

  logic [IDX_W-1:0] reqIdx, pendIdx;
  logic [TAG_W-1:0] reqTag, pendTag;

  assign reqIdx  = reqAddr[IDX_W-1:0];
  assign reqTag  = reqAddr[ADDR_W-1:IDX_W];
  assign pendIdx = pendAddr[IDX_W-1:0];
  assign pendTag = pendAddr[ADDR_W-1:IDX_W];

  assign mainHit = mainValid[reqIdx] && (mainTag[reqIdx] == reqTag);

  for (genvar e = 0; e < VB_ENTRIES; e++) begin : gVbCmp
    assign vbMatch[e] = vbValid[e] && (vbAddr[e] == reqAddr);
  end

  assign vbHit = |vbMatch;

  always_comb begin
    vbSel = '0;
    for (int e = 0; e < VB_ENTRIES; e++) begin
      if (vbMatch[e]) vbSel = VB_W'(e);
    end
  end

  logic pushVictim;
  assign pushVictim = strobes.fill && mainValid[pendIdx];

  // Main array valid bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainValid <= '0;
    end else if (strobes.swap) begin
      mainValid[reqIdx] <= 1'b1;
    end else if (strobes.fill) begin
      mainValid[pendIdx] <= 1'b1;
    end
  end

  // Main array tags and data
  always_ff @(posedge clk) begin
    if (strobes.swap) begin
      mainTag[reqIdx]  <= vbAddr[vbSel][ADDR_W-1:IDX_W];
      mainData[reqIdx] <= vbData[vbSel];
    end else if (strobes.fill) begin
      mainTag[pendIdx]  <= pendTag;
      mainData[pendIdx] <= memRspData;
    end
  end

  // Victim buffer valid bits and FIFO pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vbValid <= '0;
      vbPtr   <= '0;
    end else if (strobes.swap) begin
      vbValid[vbSel] <= mainValid[reqIdx];
    end else if (pushVictim) begin
      vbValid[vbPtr] <= 1'b1;
      vbPtr          <= (vbPtr == VB_LAST) ? '0 : vbPtr + 1'b1;
    end
  end

  // Victim buffer contents
  always_ff @(posedge clk) begin
    if (strobes.swap) begin
      vbAddr[vbSel] <= {mainTag[reqIdx], reqIdx};
      vbData[vbSel] <= mainData[reqIdx];
    end else if (pushVictim) begin
      vbAddr[vbPtr] <= {mainTag[pendIdx], pendIdx};
      vbData[vbPtr] <= mainData[pendIdx];
    end
  end

  // Pending miss address
  always_ff @(posedge clk) begin
    if (!rstN)                pendAddr <= '0;
    else if (strobes.accept)  pendAddr <= reqAddr;
  end

  assign memReqAddr = pendAddr;

  // Response register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobes.hitMain || strobes.swap || strobes.fill;
      if (strobes.hitMain)   rspData <= mainData[reqIdx];
      else if (strobes.swap) rspData <= vbData[vbSel];
      else if (strobes.fill) rspData <= memRspData;
    end
  end

  // Classification counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitCount       <= '0;
      victimHitCount <= '0;
      missCount      <= '0;
    end else begin
      if (strobes.hitMain) hitCount       <= hitCount + 1'b1;
      if (strobes.swap)    victimHitCount <= victimHitCount + 1'b1;
      if (strobes.fill)    missCount      <= missCount + 1'b1;
    end
  end

endmodule

// File: rtl/cache_vb_top.sv
module cache_vb_top
  import cache_vb_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int SETS       = 4,
  parameter int VB_ENTRIES = 4,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  victimHitCount,
  output logic [CNT_W-1:0]  missCount
);

  ctrlStrobes_t strobes;
  logic         mainHit;
  logic         vbHit;

  cache_vb_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .mainHit     (mainHit),
    .vbHit       (vbHit),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .strobes     (strobes)
  );

  cache_vb_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SETS       (SETS),
    .VB_ENTRIES (VB_ENTRIES),
    .CNT_W      (CNT_W)
  ) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .reqAddr        (reqAddr),
    .memRspData     (memRspData),
    .mainHit        (mainHit),
    .vbHit          (vbHit),
    .memReqAddr     (memReqAddr),
    .rspValid       (rspValid),
    .rspData        (rspData),
    .hitCount       (hitCount),
    .victimHitCount (victimHitCount),
    .missCount      (missCount)
  );

endmodule

// File: rtl/cache_vb_checker.sv
module cache_vb_checker #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic [CNT_W-1:0]  hitCount,
  input logic [CNT_W-1:0]  victimHitCount,
  input logic [CNT_W-1:0]  missCount
);

  // R8
  single_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  // R7
  req_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReqValid) |-> $past(reqValid && reqReady));

  // R9
  rsp_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($past(reqValid && reqReady) || $past(memRspValid)));

  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((hitCount == $past(hitCount) || hitCount == $past(hitCount) + 1'b1) &&
              (victimHitCount == $past(victimHitCount) ||
               victimHitCount == $past(victimHitCount) + 1'b1) &&
              (missCount == $past(missCount) || missCount == $past(missCount) + 1'b1)));

  // R10
  cnt_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($countones({hitCount != $past(hitCount),
                          victimHitCount != $past(victimHitCount),
                          missCount != $past(missCount)}) <= 1));

endmodule

bind cache_vb_top cache_vb_checker #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) chk_i (
  .clk            (clk),
  .rstN           (rstN),
  .reqValid       (reqValid),
  .reqReady       (reqReady),
  .rspValid       (rspValid),
  .memReqValid    (memReqValid),
  .memReqReady    (memReqReady),
  .memReqAddr     (memReqAddr),
  .memRspValid    (memRspValid),
  .hitCount       (hitCount),
  .victimHitCount (victimHitCount),
  .missCount      (missCount)
);

// File: tb/cache_vb_tb_top.sv
`timescale 1ns/1ps
module cache_vb_tb_top;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int SETS   = 4;
  localparam int VBN    = 4;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic rspValid;
  logic [DATA_W-1:0] rspData;
  logic memReqValid;
  logic memReqReady = 1'b0;
  logic [ADDR_W-1:0] memReqAddr;
  logic memRspValid = 1'b0;
  logic [DATA_W-1:0] memRspData = '0;
  logic [CNT_W-1:0] hitCount, victimHitCount, missCount;

  always #4 clk = ~clk;

  cache_vb_top #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .VB_ENTRIES(VBN), .CNT_W(CNT_W)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspData(rspData), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqAddr(memReqAddr), .memRspValid(memRspValid),
    .memRspData(memRspData), .hitCount(hitCount), .victimHitCount(victimHitCount),
    .missCount(missCount)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  typedef struct { bit v; int a; } vbEntry_t;
  vbEntry_t vbq[$];
  bit mValid[SETS];
  int mAddr[SETS];
  int expHit = 0, expVhit = 0, expMiss = 0;

  function automatic logic [DATA_W-1:0] lineOf(input logic [ADDR_W-1:0] a);
    return {8'hA5, a, ~a, a ^ 8'h3C};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // 0 = main hit, 1 = victim hit, 2 = miss; updates the model
  function automatic int classify(input int a);
    int s = a % SETS;
    if (mValid[s] && mAddr[s] == a) return 0;
    foreach (vbq[i]) begin
      if (vbq[i].v && vbq[i].a == a) begin
        vbq[i].v = mValid[s];
        vbq[i].a = mAddr[s];
        mAddr[s] = a;
        mValid[s] = 1;
        return 1;
      end
    end
    if (mValid[s]) begin
      vbEntry_t e;
      e.v = 1; e.a = mAddr[s];
      void'(vbq.pop_front());
      vbq.push_back(e);
    end
    mAddr[s] = a;
    mValid[s] = 1;
    return 2;
  endfunction

  task automatic checkCounts(input string req);
    check(hitCount == CNT_W'(expHit), req, "hitCount", hitCount, expHit);
    check(victimHitCount == CNT_W'(expVhit), req, "victimHitCount", victimHitCount, expVhit);
    check(missCount == CNT_W'(expMiss), req, "missCount", missCount, expMiss);
  endtask

  // Called at a negedge; returns at a negedge with the response observed.
  task automatic access(input int a, input string tag, input int stall, input int lat);
    int kind;
    logic [ADDR_W-1:0] aw = ADDR_W'(a);
    check(reqReady === 1'b1, "R8", "reqReady before request", reqReady, 1);
    kind = classify(a);
    reqValid = 1'b1;
    reqAddr  = aw;
    @(negedge clk);
    reqValid = 1'b0;
    if (kind != 2) begin
      if (kind == 0) expHit++; else expVhit++;
      check(rspValid === 1'b1, kind == 0 ? "R2" : "R5", {tag, " rspValid"}, rspValid, 1);
      check(rspData === lineOf(aw), kind == 0 ? "R2" : "R5", {tag, " rspData"}, rspData, lineOf(aw));
      check(memReqValid === 1'b0, kind == 0 ? "R2" : "R5", {tag, " no next-level request"}, memReqValid, 0);
      checkCounts("R10");
    end else begin
      expMiss++;
      check(memReqValid === 1'b1, "R7", {tag, " memReqValid"}, memReqValid, 1);
      check(memReqAddr === aw, "R7", {tag, " memReqAddr"}, memReqAddr, aw);
      check(rspValid === 1'b0, "R9", {tag, " no early response"}, rspValid, 0);
      check(reqReady === 1'b0, "R8", {tag, " blocked while missing"}, reqReady, 0);
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        check(memReqValid === 1'b1 && memReqAddr === aw, "R7", {tag, " request held"}, memReqAddr, aw);
      end
      memReqReady = 1'b1;
      @(negedge clk);
      memReqReady = 1'b0;
      check(memReqValid === 1'b0, "R7", {tag, " request dropped"}, memReqValid, 0);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        check(rspValid === 1'b0 && reqReady === 1'b0, "R8", {tag, " waiting"}, reqReady, 0);
      end
      memRspValid = 1'b1;
      memRspData  = lineOf(aw);
      @(negedge clk);
      memRspValid = 1'b0;
      memRspData  = '0;
      check(rspValid === 1'b1, "R7", {tag, " fill rspValid"}, rspValid, 1);
      check(rspData === lineOf(aw), "R7", {tag, " fill rspData"}, rspData, lineOf(aw));
      check(reqReady === 1'b1, "R8", {tag, " ready after fill"}, reqReady, 1);
      checkCounts("R10");
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(rspValid === 1'b0, "R9", "rspValid in idle", rspValid, 0);
      check(memReqValid === 1'b0, "R9", "memReqValid in idle", memReqValid, 0);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    for (int i = 0; i < VBN; i++) begin
      vbEntry_t e;
      e.v = 0; e.a = 0;
      vbq.push_back(e);
    end
    for (int s = 0; s < SETS; s++) begin mValid[s] = 0; mAddr[s] = 0; end

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady === 1'b1, "R1", "reqReady", reqReady, 1);
    check(rspValid === 1'b0, "R1", "rspValid", rspValid, 0);
    check(memReqValid === 1'b0, "R1", "memReqValid", memReqValid, 0);
    checkCounts("R1");

    // R2 / R7: cold miss then hit
    access(8'h00, "R7 cold", 0, 0);
    idle(1);
    access(8'h00, "R2 repeat", 0, 0);
    // R3: same low bits, different tag conflicts; R4 pushes 0x00
    access(8'h04, "R3 conflict", 2, 3);
    // R5: swap back and forth
    access(8'h00, "R5 swap a", 0, 0);
    access(8'h04, "R5 swap b", 0, 0);
    access(8'h04, "R2 after swap", 0, 0);
    idle(2);
    // R4: empty-set fills push nothing, so 0x00 stays buffered
    access(8'h01, "R4 empty1", 1, 1);
    access(8'h02, "R4 empty2", 0, 2);
    access(8'h03, "R4 empty3", 3, 0);
    access(8'h00, "R4 still buffered", 0, 0);
    // R6: FIFO overwrite on set 0 chain
    access(8'h10, "R6 c1", 0, 1);
    access(8'h20, "R6 c2", 1, 0);
    access(8'h30, "R6 c3", 0, 0);
    access(8'h40, "R6 c4", 2, 2);
    access(8'h50, "R6 c5", 0, 0);
    access(8'h00, "R6 oldest lost", 0, 0);
    access(8'h40, "R6 recent kept", 0, 0);
    idle(1);

    // Random mixed phase
    for (int n = 0; n < 400; n++) begin
      access($urandom_range(0, 6 * SETS - 1), "rand",
             $urandom_range(0, 3), $urandom_range(0, 4));
      if ($urandom_range(0, 4) == 0) idle(1);
    end
    idle(2);
    checkCounts("R10");
    check(expHit + expVhit + expMiss > 0, "R10", "total", expHit + expVhit + expMiss, 1);
    done = 1;
    finishRun();
  end

endmodule